// File: doc/BRIEF.md
# Slotted DRAM Refresh Scheduler

This block decides, cycle by cycle, when a video DMA controller spends a memory cycle on DRAM refresh. Every scanline has nine refresh opportunities at fixed cycle positions, all in the first half of the line, so the later part of the line stays free for other bus traffic. The block takes the current cycle-in-line count and a flag that marks cycles the display fetch logic has already claimed. Display fetches have priority.

A refresh slot that lands on a claimed cycle is not thrown away. It is remembered in a single pending flag and issued on the next unclaimed cycle. Only one deferred refresh can be held at a time. Any pending refresh still waiting when the line ends is discarded at cycle zero. Each issued refresh strobes `refresh_o` for one cycle. During that cycle `row_o` carries the row address from an internal counter, and the counter steps forward after every issued refresh.

Top module: `refresh_sched`

## Requirements
- R1: While `rst_ni` is low and after its release, the row counter is 0, no refresh is pending, and `refresh_o` stays low unless a slot or pending refresh is serviced.
- R2: Refresh slots are at cycles 25, 29, 33, 37, 41, 45, 49, 53 and 57 of a 114-cycle line. With nothing pending, `refresh_o` is never high on any other cycle. A line with no fetch activity yields exactly nine refreshes.
- R3: When a slot cycle has `fetch_busy_i` low, `refresh_o` is high in that same cycle.
- R4: A slot cycle with `fetch_busy_i` high sets the pending flag. The refresh is then issued on the next cycle (not cycle 0) that has `fetch_busy_i` low, and the flag clears afterwards.
- R5: Only one refresh can be pending. A slot preempted while one is already pending is dropped, so the fetch-free cycles that follow yield only one refresh.
- R6: When a pending refresh exists and a slot cycle arrives with `fetch_busy_i` low, the slot is serviced and the pending refresh stays held. It is issued on the next fetch-free cycle.
- R7: `row_o` is the counter value used by the refresh in the current cycle. The counter increments by one after each issued refresh and wraps from 255 to 0.
- R8: A pending refresh is discarded when `cycle_i` is 0. No refresh comes out of it on cycle 0 or on any later cycle.
- R9: On a line where every slot is preempted but a fetch-free cycle follows the last slot, exactly one refresh is issued, on that first free cycle.
- R10: `refresh_o` is never high while `fetch_busy_i` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, one tick per bus cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | 7 | Cycle position within the scanline, 0 to 113 |
| fetch_busy_i | input | 1 | Cycle claimed by display fetch |
| refresh_o | output | 1 | Refresh strobe for this cycle |
| row_o | output | 8 | Row address for the refresh |

## Verification
The bench targets how deferral interacts with slot timing.

- Two back-to-back preempted slots check the single-entry limit. A design that counts deferrals would emit an extra refresh.
- A free slot arriving while a refresh is pending checks that the deferred refresh survives. A design that merges the two would lose a row advance.
- A deferral carried across the line wrap must die at cycle 0. A design that ignores the wrap would emit a stray refresh early in the next line.
- A line whose slots are all claimed must still yield exactly one refresh, right after the last busy cycle.
- The row counter is driven through its 255-to-0 wrap, and a reset with a refresh pending is checked to clear it.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  localparam int LINE_CYCLES = 114;
  localparam int NUM_SLOTS   = 9;
  localparam int FIRST_SLOT  = 25;
  localparam int SLOT_STEP   = 4;
  localparam int ROW_W       = 8;
  localparam int CYC_W       = $clog2(LINE_CYCLES);
endpackage

// File: rtl/refresh_slot_decode.sv
module refresh_slot_decode #(
  parameter int CYC_W      = 7,
  parameter int NUM_SLOTS  = 9,
  parameter int FIRST_SLOT = 25,
  parameter int SLOT_STEP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CYC_W-1:0] cycle_i,
  output logic             slot_o
);
  logic [NUM_SLOTS-1:0] hit;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    localparam int Pos = FIRST_SLOT + i * SLOT_STEP;
    assign hit[i] = (cycle_i == CYC_W'(Pos));
  end

  assign slot_o = |hit;

  // R2
  slot_unique_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit));
endmodule

// File: rtl/refresh_defer.sv
module refresh_defer #(
  parameter int CYC_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CYC_W-1:0] cycle_i,
  input  logic             slot_i,
  input  logic             busy_i,
  output logic             issue_o
);
  logic pend_q, pend_d, line_start;

  assign line_start = (cycle_i == '0);
  // Slot wins a free cycle; pending waits for a free non-slot cycle.
  assign issue_o = !busy_i && (slot_i || (pend_q && !line_start));

  always_comb begin
    pend_d = pend_q;
    if (line_start)                   pend_d = 1'b0;
    else if (slot_i && busy_i)        pend_d = 1'b1;
    else if (pend_q && !busy_i && !slot_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  // R4
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_i && busy_i && !line_start) |=> pend_q);
  // R8
  pend_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start |=> !pend_q);
  // R6
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && slot_i && !busy_i && !line_start) |=> pend_q);
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int ROW_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    row_q <= '0;
    else if (adv_i) row_q <= row_q + ROW_W'(1);
  end

  assign row_o = row_q;

  // R7
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (row_q == $past(row_q) + ROW_W'(1)));
  // R7
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(row_q));
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int P_NUM_SLOTS  = NUM_SLOTS,
  parameter int P_FIRST_SLOT = FIRST_SLOT,
  parameter int P_SLOT_STEP  = SLOT_STEP,
  parameter int P_ROW_W      = ROW_W,
  parameter int P_CYC_W      = CYC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [P_CYC_W-1:0] cycle_i,
  input  logic               fetch_busy_i,
  output logic               refresh_o,
  output logic [P_ROW_W-1:0] row_o
);
  logic slot;

  refresh_slot_decode #(
    .CYC_W(P_CYC_W), .NUM_SLOTS(P_NUM_SLOTS),
    .FIRST_SLOT(P_FIRST_SLOT), .SLOT_STEP(P_SLOT_STEP)
  ) u_decode (
    .clk_i(clk_i), .rst_ni(rst_ni), .cycle_i(cycle_i), .slot_o(slot)
  );

  refresh_defer #(.CYC_W(P_CYC_W)) u_defer (
    .clk_i(clk_i), .rst_ni(rst_ni), .cycle_i(cycle_i),
    .slot_i(slot), .busy_i(fetch_busy_i), .issue_o(refresh_o)
  );

  refresh_row_ctr #(.ROW_W(P_ROW_W)) u_row (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(refresh_o), .row_o(row_o)
  );

  // R10
  no_refresh_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_busy_i |-> !refresh_o);
endmodule

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [6:0] cycle_i = '0;
  logic       fetch_busy_i = 1'b0;
  logic       refresh_o;
  logic [7:0] row_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  refresh_sched dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cycle_i(cycle_i),
    .fetch_busy_i(fetch_busy_i), .refresh_o(refresh_o), .row_o(row_o)
  );

  // {cycle, busy, expected refresh, expected row}
  localparam int NV = 20;
  localparam logic [16:0] VEC [NV] = '{
    {7'd24,  1'b0, 1'b0, 8'd0},  // R2
    {7'd25,  1'b0, 1'b1, 8'd0},  // R3
    {7'd26,  1'b0, 1'b0, 8'd1},  // R7
    {7'd29,  1'b1, 1'b0, 8'd1},  // R4 preempt
    {7'd30,  1'b0, 1'b1, 8'd1},  // R4 deferred issue
    {7'd31,  1'b0, 1'b0, 8'd2},  // R4 cleared
    {7'd33,  1'b1, 1'b0, 8'd2},  // R5
    {7'd37,  1'b1, 1'b0, 8'd2},  // R5 dropped
    {7'd38,  1'b0, 1'b1, 8'd2},  // R5
    {7'd39,  1'b0, 1'b0, 8'd3},  // R5 only one
    {7'd41,  1'b1, 1'b0, 8'd3},  // R6 setup
    {7'd45,  1'b0, 1'b1, 8'd3},  // R6 slot wins
    {7'd46,  1'b0, 1'b1, 8'd4},  // R6 pending follows
    {7'd47,  1'b0, 1'b0, 8'd5},  // R6
    {7'd57,  1'b1, 1'b0, 8'd5},  // R8 setup
    {7'd100, 1'b1, 1'b0, 8'd5},  // R10
    {7'd0,   1'b0, 1'b0, 8'd5},  // R8 discard
    {7'd1,   1'b0, 1'b0, 8'd5},  // R8
    {7'd60,  1'b0, 1'b0, 8'd5},  // R2
    {7'd113, 1'b0, 1'b0, 8'd5}   // R2
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int cyc, input bit busy);
    @(negedge clk_i);
    cycle_i = 7'(cyc);
    fetch_busy_i = busy;
    #1;
  endtask

  function automatic bit is_slot(input int c);
    return c >= 25 && c <= 57 && ((c - 25) % 4 == 0);
  endfunction

  initial begin
    int row_exp, cnt, first;
    // R1 reset state
    #5;
    check("R1 row in reset", row_o, 0);
    check("R1 strobe in reset", refresh_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    step(60, 0);
    check("R1 no strobe after reset", refresh_o, 0);

    for (int i = 0; i < NV; i++) begin
      step(int'(VEC[i][16:10]), VEC[i][9]);
      check($sformatf("vec%0d refresh", i), refresh_o, int'(VEC[i][8]));
      check($sformatf("vec%0d row", i), row_o, int'(VEC[i][7:0]));
    end

    // R2 free line: nine refreshes exactly on slots
    row_exp = row_o; cnt = 0;
    for (int c = 0; c < 114; c++) begin
      step(c, 0);
      if (refresh_o !== is_slot(c)) check("R2 slot position", refresh_o, is_slot(c));
      cnt += refresh_o;
    end
    check("R2 refreshes per free line", cnt, 9);
    step(60, 0);
    check("R7 row after free line", row_o, (row_exp + 9) % 256);

    // R9 heavy line: busy through cycle 57, one refresh at 58; R10 each cycle
    row_exp = row_o; cnt = 0; first = -1;
    for (int c = 0; c < 114; c++) begin
      step(c, c <= 57);
      if (c <= 57 && refresh_o) check("R10 strobe while busy", refresh_o, 0);
      if (refresh_o && first < 0) first = c;
      cnt += refresh_o;
    end
    check("R9 refreshes on heavy line", cnt, 1);
    check("R9 refresh cycle", first, 58);

    // R7 wrap
    row_exp = row_o;
    for (int k = row_exp; k < 255; k++) step(25, 0);
    step(60, 0);
    check("R7 row before wrap", row_o, 255);
    step(25, 0);
    check("R7 strobe at 255", refresh_o, 1);
    step(60, 0);
    check("R7 row wraps", row_o, 0);

    // R1 reset clears pending
    step(29, 1);
    @(negedge clk_i); rst_ni = 1'b0;
    cycle_i = 7'd60; fetch_busy_i = 1'b0; #1;
    check("R1 pending cleared by reset", refresh_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    step(60, 0);
    check("R1 no stale refresh", refresh_o, 0);
    check("R1 row after reset", row_o, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule